// File: doc/BRIEF.md
# 4:2:2 Pixel Bus Formatter

This block turns a stream of 4:2:2 component video pixels into a 16-bit output pixel bus with a matching line-locked clock output. Everything runs from one core clock at twice the pixel rate, so every pixel owns a pair of core cycles: a luma slot and then a chroma slot. Each transfer on the input handshake carries one luma byte and both chroma bytes of the pixel's 4:2:2 pair. The block picks Cb or Cr from these by pixel order.

A 4-bit format code selects between two bus layouts at run time. In the narrow layout, luma and chroma bytes interleave on the upper lane at the core rate, and the lower lane is switched off. In the wide layout, the upper lane carries luma and the lower lane carries chroma, with each word held for both slots. Software can also swap the chroma order, invert the clock output, and choose whether the clock pin carries the pixel-slot clock or the word clock. All of these settings are sampled only at a pixel boundary. When no pixel is offered, the bus carries blanking levels.

The clock output is a registered, data-like signal. The "full-rate" clock is high during the luma slot and low during the chroma slot. The "half-rate" clock changes level at each word boundary.

Top module: `pixfmt_top`

## Requirements
- R1: After reset, the bus holds luma 0x10 on pbus[15:8] and chroma 0x80 on pbus[7:0], pbus_oe is 2'b10 (upper lane on, lower lane off), lclk_o is 0, fmt_err is 0, in_ready is 1, and the narrow layout is active.
- R2: With the narrow layout (format code 4'b0011), pbus[15:8] shows the pixel's luma in the first cycle after the pixel boundary and its chroma byte in the second cycle. pbus_oe is 2'b10.
- R3: With the wide layout (format code 4'b0010), pbus[15:8] shows luma and pbus[7:0] shows chroma. Both are held unchanged for the two cycles of the pixel, and pbus_oe is 2'b11.
- R4: Any format code from 4'b0110 to 4'b1111 leaves the layout unchanged. It also sets fmt_err one cycle after it is present, and fmt_err then stays 1 until reset. Codes 4'b0000, 4'b0001, 4'b0100 and 4'b0101 leave the layout unchanged without setting fmt_err.
- R5: Accepted pixels take their chroma byte alternately: Cb for the 1st, 3rd, … pixel after reset and Cr for the 2nd, 4th, …. With chroma_swap at 1, the order inverts. Blanking pixels do not advance the order.
- R6: With clk_pad_sel 3'b000, or any value except 3'b101, lclk_o is high in the luma cycle and low in the chroma cycle. With 3'b101, lclk_o is constant over each pixel and inverts at every pixel boundary, starting high for the first pixel after reset.
- R7: With clk_invert at 1, lclk_o is the complement of the level given by R6.
- R8: fmt_sel, chroma_swap, clk_pad_sel and clk_invert are sampled only on a clock edge where in_ready is 1. Changes made between such edges never affect the pixel in progress.
- R9: in_ready is 1 in the first cycle after reset and then alternates every cycle. A pixel is taken on an edge where both in_valid and in_ready are 1.
- R10: A pixel boundary with in_valid at 0 puts out a blanking pixel with luma 0x10 and chroma 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 4 | Bus layout code |
| clk_pad_sel | input | 3 | Clock pin source select |
| chroma_swap | input | 1 | Inverts Cb/Cr order |
| clk_invert | input | 1 | Inverts clock output polarity |
| in_valid | input | 1 | Input pixel offered |
| in_ready | output | 1 | Pixel boundary, input taken on this edge |
| in_y | input | 8 | Input luma |
| in_cb | input | 8 | Input blue-difference chroma |
| in_cr | input | 8 | Input red-difference chroma |
| pbus | output | 16 | Output pixel bus, upper lane [15:8], lower lane [7:0] |
| pbus_oe | output | 2 | Lane output enables, bit 1 upper, bit 0 lower |
| lclk_o | output | 1 | Line-locked clock output |
| fmt_err | output | 1 | Sticky reserved-format flag |

## Verification
Several things can happen on the same pixel-boundary edge: a layout change, a chroma swap, a clock source or polarity change, and the take or non-take of a pixel. If their timing is wrong, one pixel can be split across two settings. The bench toggles fmt_sel for a single cycle at both slot offsets and changes several settings together while pixels are flowing with and without gaps. A cycle-accurate behavioural model compares the bus, the enables, the clock, in_ready and the error flag every cycle.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;

   typedef enum logic {
      LAYOUT_NARROW = 1'b0,
      LAYOUT_WIDE   = 1'b1
   } lane_layout_e;

   typedef struct packed {
      lane_layout_e layout;
      logic         swap;
      logic         slow_clk;
      logic         inv_clk;
   } pix_cfg_t;

   localparam pix_cfg_t CFG_RESET = '{
      layout:   LAYOUT_NARROW,
      swap:     1'b0,
      slow_clk: 1'b0,
      inv_clk:  1'b0
   };

endpackage

// File: rtl/pixfmt_cfg.sv
module pixfmt_cfg
   import pixfmt_pkg::*;
#(
   parameter int          SEL_W       = 4,
   parameter int          PAD_W       = 3,
   parameter logic [SEL_W-1:0] CODE_NARROW = 4'b0011,
   parameter logic [SEL_W-1:0] CODE_WIDE   = 4'b0010,
   parameter logic [SEL_W-1:0] RSV_FIRST   = 4'b0110,
   parameter logic [PAD_W-1:0] PAD_SLOW    = 3'b101
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boundary,
   input  logic [SEL_W-1:0] fmt_sel,
   input  logic [PAD_W-1:0] pad_sel,
   input  logic             swap_i,
   input  logic             inv_i,
   output pix_cfg_t         cfg_d,
   output logic             err_o
);

   pix_cfg_t cfg_q;
   logic     rsv_code;
   logic     err_q;

   assign rsv_code = (fmt_sel >= RSV_FIRST);

   // the setting that governs the pixel being loaded on this edge
   always_comb begin
      cfg_d = cfg_q;
      if (boundary) begin
         if (fmt_sel == CODE_WIDE) begin
            cfg_d.layout = LAYOUT_WIDE;
         end else if (fmt_sel == CODE_NARROW) begin
            cfg_d.layout = LAYOUT_NARROW;
         end
         cfg_d.swap     = swap_i;
         cfg_d.slow_clk = (pad_sel == PAD_SLOW);
         cfg_d.inv_clk  = inv_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
         err_q <= 1'b0;
      end else begin
         cfg_q <= cfg_d;
         err_q <= err_q | rsv_code;
      end
   end

   assign err_o = err_q;

endmodule

// File: rtl/pixfmt_pair.sv
module pixfmt_pair #(
   parameter int                DATA_W   = 8,
   parameter logic [DATA_W-1:0] BLANK_Y  = 8'h10,
   parameter logic [DATA_W-1:0] BLANK_C  = 8'h80,
   parameter bit                CB_FIRST = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_y,
   input  logic [DATA_W-1:0] in_cb,
   input  logic [DATA_W-1:0] in_cr,
   input  logic              swap_d,
   output logic [DATA_W-1:0] cap_y,
   output logic [DATA_W-1:0] cap_c
);

   logic odd_q;
   logic take;
   logic pick_cr;

   assign take = load & in_valid;

   generate
      if (CB_FIRST) begin : g_cb_lead
         assign pick_cr = odd_q ^ swap_d;
      end else begin : g_cr_lead
         assign pick_cr = ~(odd_q ^ swap_d);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         odd_q <= 1'b0;
      end else if (take) begin
         odd_q <= ~odd_q;
      end
   end

   always_comb begin
      if (in_valid) begin
         cap_y = in_y;
         cap_c = pick_cr ? in_cr : in_cb;
      end else begin
         cap_y = BLANK_Y;
         cap_c = BLANK_C;
      end
   end

endmodule

// File: rtl/pixfmt_lanes.sv
module pixfmt_lanes #(
   parameter int                DATA_W  = 8,
   parameter int                LANES   = 2,
   parameter logic [DATA_W-1:0] BLANK_Y = 8'h10,
   parameter logic [DATA_W-1:0] BLANK_C = 8'h80
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic                    wide_d,
   input  logic [DATA_W-1:0]       cap_y,
   input  logic [DATA_W-1:0]       cap_c,
   output logic [LANES*DATA_W-1:0] bus_o,
   output logic [LANES-1:0]        oe_o
);

   localparam int HI = LANES - 1;

   logic [DATA_W-1:0] hold_c_q;
   logic [DATA_W-1:0] lane_q [LANES];
   logic [LANES-1:0]  oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_c_q <= BLANK_C;
      end else if (load) begin
         hold_c_q <= cap_c;
      end
   end

   // upper lane: luma, then luma again (wide) or chroma (narrow)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_q[HI] <= BLANK_Y;
      end else if (load) begin
         lane_q[HI] <= cap_y;
      end else if (!wide_d) begin
         lane_q[HI] <= hold_c_q;
      end
   end

   generate
      for (genvar l = 0; l < HI; l++) begin : g_low
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q[l] <= BLANK_C;
               oe_q[l]   <= 1'b0;
            end else if (load) begin
               lane_q[l] <= cap_c;
               oe_q[l]   <= wide_d;
            end
         end
      end
      for (genvar l = 0; l < LANES; l++) begin : g_pack
         assign bus_o[l*DATA_W +: DATA_W] = lane_q[l];
      end
   endgenerate

   assign oe_q[HI] = 1'b1;
   assign oe_o     = oe_q;

endmodule

// File: rtl/pixfmt_clkgen.sv
module pixfmt_clkgen (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic slow_d,
   input  logic inv_d,
   output logic lclk_o
);

   logic word_q;
   logic word_d;
   logic level;
   logic lclk_q;

   assign word_d = load ? ~word_q : word_q;
   assign level  = slow_d ? word_d : load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= 1'b0;
         lclk_q <= 1'b0;
      end else begin
         word_q <= word_d;
         lclk_q <= level ^ inv_d;
      end
   end

   assign lclk_o = lclk_q;

endmodule

// File: rtl/pixfmt_top.sv
module pixfmt_top
   import pixfmt_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                SEL_W       = 4,
   parameter int                PAD_W       = 3,
   parameter logic [SEL_W-1:0]  CODE_NARROW = 4'b0011,
   parameter logic [SEL_W-1:0]  CODE_WIDE   = 4'b0010,
   parameter logic [SEL_W-1:0]  RSV_FIRST   = 4'b0110,
   parameter logic [PAD_W-1:0]  PAD_SLOW    = 3'b101,
   parameter logic [DATA_W-1:0] BLANK_Y     = 8'h10,
   parameter logic [DATA_W-1:0] BLANK_C     = 8'h80,
   parameter bit                CB_FIRST    = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SEL_W-1:0]    fmt_sel,
   input  logic [PAD_W-1:0]    clk_pad_sel,
   input  logic                chroma_swap,
   input  logic                clk_invert,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [DATA_W-1:0]   in_y,
   input  logic [DATA_W-1:0]   in_cb,
   input  logic [DATA_W-1:0]   in_cr,
   output logic [2*DATA_W-1:0] pbus,
   output logic [1:0]          pbus_oe,
   output logic                lclk_o,
   output logic                fmt_err
);

   localparam int LANES = 2;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("pixfmt_top: DATA_W must be at least 2");
      end
      if (CODE_NARROW == CODE_WIDE) begin : g_bad_codes
         $error("pixfmt_top: layout codes must differ");
      end
      if (CODE_NARROW >= RSV_FIRST || CODE_WIDE >= RSV_FIRST) begin : g_bad_rsv
         $error("pixfmt_top: layout codes fall in the reserved range");
      end
   endgenerate

   logic              chroma_slot_q;
   logic              boundary;
   pix_cfg_t          cfg_d;
   logic [DATA_W-1:0] cap_y;
   logic [DATA_W-1:0] cap_c;

   // slot 1 = chroma slot showing; the next edge starts a new pixel
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chroma_slot_q <= 1'b1;
      end else begin
         chroma_slot_q <= ~chroma_slot_q;
      end
   end

   assign boundary = chroma_slot_q;
   assign in_ready = chroma_slot_q;

   pixfmt_cfg #(
      .SEL_W       (SEL_W),
      .PAD_W       (PAD_W),
      .CODE_NARROW (CODE_NARROW),
      .CODE_WIDE   (CODE_WIDE),
      .RSV_FIRST   (RSV_FIRST),
      .PAD_SLOW    (PAD_SLOW)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .boundary (boundary),
      .fmt_sel  (fmt_sel),
      .pad_sel  (clk_pad_sel),
      .swap_i   (chroma_swap),
      .inv_i    (clk_invert),
      .cfg_d    (cfg_d),
      .err_o    (fmt_err)
   );

   pixfmt_pair #(
      .DATA_W   (DATA_W),
      .BLANK_Y  (BLANK_Y),
      .BLANK_C  (BLANK_C),
      .CB_FIRST (CB_FIRST)
   ) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (boundary),
      .in_valid (in_valid),
      .in_y     (in_y),
      .in_cb    (in_cb),
      .in_cr    (in_cr),
      .swap_d   (cfg_d.swap),
      .cap_y    (cap_y),
      .cap_c    (cap_c)
   );

   pixfmt_lanes #(
      .DATA_W  (DATA_W),
      .LANES   (LANES),
      .BLANK_Y (BLANK_Y),
      .BLANK_C (BLANK_C)
   ) u_lanes (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (boundary),
      .wide_d (cfg_d.layout == LAYOUT_WIDE),
      .cap_y  (cap_y),
      .cap_c  (cap_c),
      .bus_o  (pbus),
      .oe_o   (pbus_oe)
   );

   pixfmt_clkgen u_clk (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (boundary),
      .slow_d (cfg_d.slow_clk),
      .inv_d  (cfg_d.inv_clk),
      .lclk_o (lclk_o)
   );

endmodule

// File: rtl/pixfmt_chk.sv
module pixfmt_chk #(
   parameter int               DATA_W    = 8,
   parameter int               SEL_W     = 4,
   parameter logic [SEL_W-1:0] RSV_FIRST = 4'b0110
)(
   input logic                clk,
   input logic                rst_n,
   input logic [SEL_W-1:0]    fmt_sel,
   input logic                in_ready,
   input logic [2*DATA_W-1:0] pbus,
   input logic [1:0]          pbus_oe,
   input logic                fmt_err
);

   // R9
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> !in_ready);

   // R9
   ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> in_ready);

   // R3
   wide_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && pbus_oe[0]) |-> $stable(pbus));

   // R8
   oe_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> $stable(pbus_oe));

   // R4
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |=> fmt_err);

   // R4
   err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_sel >= RSV_FIRST) |=> fmt_err);

endmodule

bind pixfmt_top pixfmt_chk #(
   .DATA_W    (DATA_W),
   .SEL_W     (SEL_W),
   .RSV_FIRST (RSV_FIRST)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fmt_sel  (fmt_sel),
   .in_ready (in_ready),
   .pbus     (pbus),
   .pbus_oe  (pbus_oe),
   .fmt_err  (fmt_err)
);

// File: tb/sim_pixfmt_top.sv
module sim_pixfmt_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  fmt_sel = 4'b0011;
   logic [2:0]  clk_pad_sel = 3'b000;
   logic        chroma_swap = 1'b0;
   logic        clk_invert = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_y = 8'h00;
   logic [7:0]  in_cb = 8'h00;
   logic [7:0]  in_cr = 8'h00;
   logic [15:0] pbus;
   logic [1:0]  pbus_oe;
   logic        lclk_o;
   logic        fmt_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   string note = "R1 reset";

   always #2 clk = ~clk;   // 250 MHz

   pixfmt_top u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .fmt_sel     (fmt_sel),
      .clk_pad_sel (clk_pad_sel),
      .chroma_swap (chroma_swap),
      .clk_invert  (clk_invert),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_y        (in_y),
      .in_cb       (in_cb),
      .in_cr       (in_cr),
      .pbus        (pbus),
      .pbus_oe     (pbus_oe),
      .lclk_o      (lclk_o),
      .fmt_err     (fmt_err)
   );

   // behavioural reference model
   bit       m_live = 1'b0;
   bit       m_boundary;
   bit       m_wide, m_swap, m_slow, m_inv, m_word, m_err;
   int       m_taken;
   logic [7:0] m_y, m_c, m_hi, m_lo;
   logic [1:0] m_oe;
   logic       m_clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_live = 1'b0;
         m_boundary = 1'b1;
         m_wide = 0; m_swap = 0; m_slow = 0; m_inv = 0; m_word = 0; m_err = 0;
         m_taken = 0;
         m_y = 8'h10; m_c = 8'h80; m_hi = 8'h10; m_lo = 8'h80;
         m_oe = 2'b10; m_clk = 1'b0;
      end else begin
         m_live = 1'b1;
         if (fmt_sel >= 4'b0110) m_err = 1'b1;
         if (m_boundary) begin
            if (fmt_sel == 4'b0010) m_wide = 1;
            if (fmt_sel == 4'b0011) m_wide = 0;
            m_swap = chroma_swap;
            m_slow = (clk_pad_sel == 3'b101);
            m_inv  = clk_invert;
            if (in_valid) begin
               m_y = in_y;
               m_c = (((m_taken % 2) == 1) != m_swap) ? in_cr : in_cb;
               m_taken++;
            end else begin
               m_y = 8'h10;
               m_c = 8'h80;
            end
            m_word = !m_word;
            m_hi = m_y;
            m_lo = m_c;
            m_oe = {1'b1, m_wide};
            m_clk = m_inv ^ (m_slow ? m_word : 1'b1);
            m_boundary = 1'b0;
         end else begin
            m_hi = m_wide ? m_y : m_c;
            m_clk = m_inv ^ (m_slow ? m_word : 1'b0);
            m_boundary = 1'b1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s (%s) at %0t: actual 0x%0h expected 0x%0h", req, note, $time, act, exp);
      end
   endtask

   // compare every cycle away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(in_ready == m_boundary, "R9", int'(in_ready), int'(m_boundary));
         check(pbus[15:8] == m_hi, m_wide ? "R3" : "R2", int'(pbus[15:8]), int'(m_hi));
         check(pbus_oe == m_oe, "R2", int'(pbus_oe), int'(m_oe));
         if (m_oe[0]) check(pbus[7:0] == m_lo, "R3", int'(pbus[7:0]), int'(m_lo));
         check(lclk_o == m_clk, m_inv ? "R7" : "R6", int'(lclk_o), int'(m_clk));
         check(fmt_err == m_err, "R4", int'(fmt_err), int'(m_err));
      end
   end

   logic [7:0] seed = 8'h21;

   task automatic stream(input int n, input int gap);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = (gap == 0) || ((k % gap) != 0);
         seed  = seed + 8'd7;
         in_y  = seed;
         in_cb = seed ^ 8'h5A;
         in_cr = seed + 8'h33;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values checked explicitly before the first live edge
      check(pbus == 16'h1080, "R1", int'(pbus), 16'h1080);
      check(pbus_oe == 2'b10 && !lclk_o && !fmt_err && in_ready, "R1",
            int'({pbus_oe, lclk_o, fmt_err, in_ready}), 5'b10001);
      note = "R2 narrow";               stream(16, 0);
      note = "R10 blanking gaps";       stream(16, 3);
      note = "R3 wide";      fmt_sel = 4'b0010; stream(16, 0);
      note = "R5 swap";      chroma_swap = 1'b1; stream(12, 2);
      note = "R6 slow clock"; clk_pad_sel = 3'b101; stream(12, 0);
      note = "R6 other pad";  clk_pad_sel = 3'b011; stream(8, 0);
      note = "R7 invert";     clk_invert = 1'b1; stream(8, 0);
      clk_pad_sel = 3'b101; stream(8, 0);
      note = "R8 mid-pixel change";
      @(negedge clk); fmt_sel = 4'b0011;
      @(negedge clk); fmt_sel = 4'b0010; stream(4, 0);
      @(negedge clk); fmt_sel = 4'b0011; chroma_swap = 1'b0; clk_invert = 1'b0;
      @(negedge clk); fmt_sel = 4'b0010; chroma_swap = 1'b1; clk_invert = 1'b1; stream(6, 0);
      note = "R4 undefined code"; fmt_sel = 4'b0100; stream(8, 0);
      note = "R4 reserved code";  fmt_sel = 4'b1001; stream(1, 0);
      fmt_sel = 4'b0011; stream(10, 0);
      fmt_sel = 4'b1111; stream(1, 0);
      fmt_sel = 4'b0010; stream(10, 4);
      note = "R1 second reset";   do_reset();
      fmt_sel = 4'b0011; chroma_swap = 1'b0; clk_invert = 1'b0; clk_pad_sel = 3'b000;
      stream(10, 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual running expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule